// File: doc/BRIEF.md
# Thermometer-Code Single-Input-Change Pattern Generator

This block produces test stimulus for built-in self-test of a combinational circuit. The stimulus is built to keep switching activity in the circuit under test low. A small binary counter sweeps up from zero to its top value and then back down to zero, and repeats this for as long as it is enabled. A combinational decoder turns the count into a thermometer word: for a count k, the lowest k+1 bits are high and all other bits are low. Each enabled step changes the count by exactly one, so each new pattern differs from the one before it in exactly one bit.

With the default 3-bit counter the output is 8 bits wide and one sweep covers 8 distinct vectors. Bit 0 of the pattern is always 1. The generator also reports the direction that the next step will take. It raises a one-cycle done pulse once the up sweep has delivered all of its vectors. When enable is low, everything holds. The circuit under test and any response analysis sit outside this block.

Top module: `thermo_sic_tpg`

## Requirements
- R1: While reset is asserted and right after it, the pattern is 8'h01 (count 0), the direction output is 1 (up) and done is 0. Reset is asynchronous, active low, and released synchronously after two clock edges.
- R2: Pattern bit i is 1 exactly when i is less than or equal to the internal count. Bit 0 is therefore always 1, and the pattern is always a valid thermometer word.
- R3: Starting at count 0 with direction up, each rising edge with enable high raises the count by one, up to the top value 7 (pattern 8'hFF).
- R4: The count turns around at both ends without repeating or skipping a value. The sequence of counts is 0,1,...,7,6,...,1,0,1,... with a period of 14 enabled steps.
- R5: The direction output gives the direction of the next enabled step (1 = up, 0 = down). It becomes 0 when the count reaches 7 and becomes 1 when the count reaches 0.
- R6: On an edge with enable low, the pattern, the direction and the count stay unchanged, and done is 0 after that edge.
- R7: done is 1 for exactly the one cycle that follows the enabled step out of count 7, which is the step after the eighth up-sweep pattern. It is 0 in every other cycle.
- R8: Each enabled step changes exactly one pattern bit (Hamming distance 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Step enable; the generator holds when low |
| pat_o | output | 8 | Thermometer test pattern (width 2**CNT_W) |
| dir_up_o | output | 1 | Direction of the next step, 1 = up |
| done_o | output | 1 | One-cycle pulse after the up sweep completes |

## Verification
The bench builds the block with its default 3-bit counter, so every count value, both turnarounds and the whole 14-step period come up many times in one short run. A bench model of the count and direction predicts the thermometer word, the direction and the done pulse, using shifts and arithmetic. Enable is driven both as an unbroken run and in irregular gaps, which places holds on the end points as well as mid-sweep. A reset asserted mid-sweep checks the asynchronous clear and the synchronous release.

// File: rtl/thermo_sic_pkg.sv
package thermo_sic_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/thermo_sic_rst_sync.sv
module thermo_sic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/thermo_sic_bounce_cnt.sv
module thermo_sic_bounce_cnt
  import thermo_sic_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output dir_e             dir_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  dir_e             dir_q, dir_d;
  logic             done_q, done_d;

  // next-state: step by one, turn around on arrival at an end point
  always_comb begin
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    done_d = 1'b0;
    if (en_i) begin
      done_d = (cnt_q == TOP);
      if (dir_q == DIR_UP) begin
        cnt_d = cnt_q + ONE;
        if (cnt_q + ONE == TOP) dir_d = DIR_DOWN;
      end else begin
        cnt_d = cnt_q - ONE;
        if (cnt_q == ONE) dir_d = DIR_UP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dir_q  <= DIR_UP;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      done_q <= done_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign dir_o  = dir_q;
  assign done_o = done_q;
endmodule

// File: rtl/thermo_sic_decode.sv
module thermo_sic_decode #(
  parameter int CNT_W = 3,
  localparam int PAT_W = 1 << CNT_W
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [PAT_W-1:0] therm_o
);
  for (genvar i = 0; i < PAT_W; i++) begin : g_bit
    if (i == 0) begin : g_const
      assign therm_o[i] = 1'b1;
    end else begin : g_cmp
      assign therm_o[i] = (cnt_i >= CNT_W'(i));
    end
  end
endmodule

// File: rtl/thermo_sic_tpg.sv
module thermo_sic_tpg
  import thermo_sic_pkg::*;
#(
  parameter int CNT_W = 3,
  localparam int PAT_W = 1 << CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [PAT_W-1:0] pat_o,
  output logic             dir_up_o,
  output logic             done_o
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt;
  dir_e             dir;

  thermo_sic_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  thermo_sic_bounce_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (en_i),
    .cnt_o  (cnt),
    .dir_o  (dir),
    .done_o (done_o)
  );

  thermo_sic_decode #(.CNT_W(CNT_W)) u_dec (
    .cnt_i   (cnt),
    .therm_o (pat_o)
  );

  assign dir_up_o = (dir == DIR_UP);
endmodule

// File: rtl/thermo_sic_tpg_chk.sv
module thermo_sic_tpg_chk #(
  parameter int PAT_W = 8
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             en_i,
  input logic [PAT_W-1:0] pat_o,
  input logic             dir_up_o,
  input logic             done_o
);
  localparam logic [PAT_W-1:0] ONE = PAT_W'(1);

  a_r2_therm_shape: assert property (@(posedge clk_i) disable iff (!rst_n)
    pat_o[0] && ((pat_o & (pat_o + ONE)) == '0));

  a_r8_one_bit_step: assert property (@(posedge clk_i) disable iff (!rst_n)
    en_i |=> ($countones(pat_o ^ $past(pat_o)) == 1));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> ($stable(pat_o) && $stable(dir_up_o) && !done_o));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r5_top_turns_down: assert property (@(posedge clk_i) disable iff (!rst_n)
    pat_o[PAT_W-1] |-> !dir_up_o);

  a_r5_bottom_turns_up: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pat_o == ONE) |-> dir_up_o);
endmodule

bind thermo_sic_tpg thermo_sic_tpg_chk #(.PAT_W(PAT_W)) chk_i (
  .clk_i    (clk_i),
  .rst_n    (rst_sync_n),
  .en_i     (en_i),
  .pat_o    (pat_o),
  .dir_up_o (dir_up_o),
  .done_o   (done_o)
);

// File: tb/thermo_sic_tpg_tb_top.sv
module thermo_sic_tpg_tb_top;
  localparam int CNT_W = 3;
  localparam int PAT_W = 1 << CNT_W;
  localparam int TOP   = PAT_W - 1;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             en_i;
  logic [PAT_W-1:0] pat_o;
  logic             dir_up_o;
  logic             done_o;

  int errors = 0;
  int checks = 0;
  int m_cnt  = 0;
  int m_dir  = 1;
  int m_done = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  thermo_sic_tpg #(.CNT_W(CNT_W)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .pat_o    (pat_o),
    .dir_up_o (dir_up_o),
    .done_o   (done_o)
  );

  function automatic logic [PAT_W-1:0] therm(input int k);
    return PAT_W'((1 << (k + 1)) - 1);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_dir = 1; m_done = 0;
  endtask

  task automatic step(input bit en);
    logic [PAT_W-1:0] prev;
    @(negedge clk);
    en_i = en;
    prev = pat_o;
    @(posedge clk);
    if (en) begin
      m_done = (m_cnt == TOP);
      if (m_dir == 1) begin
        m_cnt++;
        if (m_cnt == TOP) m_dir = 0;
      end else begin
        m_cnt--;
        if (m_cnt == 0) m_dir = 1;
      end
    end else begin
      m_done = 0;
    end
    #1;
    check(m_dir == 1 ? "R2 R3 pattern" : "R2 R4 pattern", int'(pat_o), int'(therm(m_cnt)));
    check("R5 direction", int'(dir_up_o), m_dir);
    check("R7 done", int'(done_o), m_done);
    if (en) check("R8 hamming", $countones(pat_o ^ prev), 1);
    else    check("R6 hold", int'(pat_o), int'(prev));
  endtask

  task automatic do_reset();
    @(negedge clk);
    en_i   = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R1 reset pattern", int'(pat_o), 1);
    check("R1 reset dir", int'(dir_up_o), 1);
    check("R1 reset done", int'(done_o), 0);
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) step(1'b0);
  endtask

  initial begin
    en_i   = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    do_reset();
    // two and a half full bounce periods, unbroken enable
    for (int i = 0; i < 35; i++) step(1'b1);
    // irregular enable gaps, holds land on end points and mid-sweep
    for (int i = 0; i < 60; i++) step((i % 5) != 3 && (i % 7) != 6);
    // reset mid-sweep, then continue
    for (int i = 0; i < 4; i++) step(1'b1);
    do_reset();
    for (int i = 0; i < 20; i++) step(1'b1);
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule